// File: doc/BRIEF.md
# Wide Counter with Coherent Two-Word Read

This block holds a wide event counter that software reads through a narrower word port. Each pulse on the hardware increment input adds one to the counter. Reading the counter clears it. The counter is split into words, and word 0 holds the least significant bits.

A read of word 0 returns the live low bits. In that same cycle, the block copies the whole counter into a snapshot buffer, and the counter restarts from zero. Reads of any higher word return the snapshot, not the live value. A read sequence that starts at word 0 therefore gives halves that all come from one sample. Read data is returned one cycle after the request, together with a valid flag. The access and modify strobes pulse only in the cycle when the snapshot is taken.

Top module: `wide_cnt_snap`

## Requirements
- R1: After reset the counter and the snapshot are zero, and `rd_data_o`/`rd_data_valid_o` are low.
- R2: While `inc_i` is high and no word-0 read occurs, the counter grows by exactly one per cycle.
- R3: The counter saturates at all ones and never wraps to zero through incrementing.
- R4: A read of word address 0 returns the live counter bits [WORD_W-1:0] as they were in the request cycle.
- R5: A read of word address 0 loads the full counter into the snapshot, and a read of word address k (1 <= k < CNT_W/WORD_W) returns snapshot bits [(k+1)*WORD_W-1:k*WORD_W].
- R6: A read of word address 0 clears the counter in the following cycle. If `inc_i` is high in the read cycle, the counter becomes 1 instead.
- R7: `acc_strb_o` and `mod_strb_o` are high exactly in the cycles when a word-0 read is requested.
- R8: A read of an address at or above CNT_W/WORD_W returns zero with valid set, and it neither clears the counter nor loads the snapshot.
- R9: The snapshot keeps its value until the next word-0 read, so repeated upper-word reads return the same data.
- R10: `rd_data_valid_o` equals `rd_valid_i` delayed by one cycle, and `rd_data_o` is zero whenever `rd_data_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Hardware increment pulse |
| rd_valid_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_data_o | output | WORD_W | Read data, one cycle after the request |
| rd_data_valid_o | output | 1 | Read data valid |
| acc_strb_o | output | 1 | Software access strobe (snapshot taken) |
| mod_strb_o | output | 1 | Software modify strobe (read-clear applied) |

## Verification
The counter and the snapshot can only be seen through reads. An error in either one therefore shows up on `rd_data_o` one cycle after the next word-0 read (counter) or the next upper-word read (snapshot). If the clear is wrong, a lost increment or a missed clear appears in the second word-0 read after the fault. Saturation is tested on a second, narrow instance, where the all-ones value can be reached within a few hundred cycles. A reference model in the bench tracks the expected data for every cycle, so any mismatch is reported in the cycle when it reaches the port.

// File: rtl/wide_cnt_snap.sv
module wide_cnt_snap #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_data_valid_o,
  output logic              acc_strb_o,
  output logic              mod_strb_o
);
  localparam int NW = CNT_W / WORD_W;
  localparam logic [ADDR_W:0] NW_A = (ADDR_W+1)'(NW);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, snap_q;
  logic [WORD_W-1:0] word_v [NW];
  logic [WORD_W-1:0] sel_word;
  logic              sample, mapped;

  assign sample = rd_valid_i && (rd_addr_i == '0);
  assign mapped = rd_valid_i && ({1'b0, rd_addr_i} < NW_A);
  assign acc_strb_o = sample;
  assign mod_strb_o = sample;

  genvar g;
  generate
    for (g = 0; g < NW; g++) begin : g_word
      if (g == 0) begin : g_live
        assign word_v[g] = cnt_q[WORD_W-1:0];
      end else begin : g_buf
        assign word_v[g] = snap_q[g*WORD_W +: WORD_W];
      end
    end
  endgenerate

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NW; i++)
      if (rd_addr_i == ADDR_W'(i)) sel_word = word_v[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sample) begin
      cnt_q <= inc_i ? CNT_ONE : '0;
    end else if (inc_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (sample) snap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o       <= '0;
      rd_data_valid_o <= 1'b0;
    end else begin
      rd_data_o       <= mapped ? sel_word : '0;
      rd_data_valid_o <= rd_valid_i;
    end
  end
endmodule

// File: rtl/wide_cnt_snap_chk.sv
module wide_cnt_snap_chk #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inc_i,
  input logic              rd_valid_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              rd_data_valid_o,
  input logic              acc_strb_o,
  input logic              mod_strb_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  snap_q
);
  logic lo_rd;
  assign lo_rd = rd_valid_i && (rd_addr_i == '0);

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_rd && inc_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_rd && cnt_q == '1) |=> cnt_q == '1);
  assert_live_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> rd_data_o == $past(cnt_q[WORD_W-1:0]));
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> snap_q == $past(cnt_q));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && !inc_i) |=> cnt_q == '0);
  assert_clear_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && inc_i) |=> cnt_q == CNT_W'(1));
  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strb_o || mod_strb_o) |-> (rd_valid_i && acc_strb_o == mod_strb_o));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd |=> $stable(snap_q));
  assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> rd_data_valid_o);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> (!rd_data_valid_o && rd_data_o == '0));
endmodule

bind wide_cnt_snap wide_cnt_snap_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o), .rd_data_valid_o(rd_data_valid_o), .acc_strb_o(acc_strb_o),
  .mod_strb_o(mod_strb_o), .cnt_q(cnt_q), .snap_q(snap_q));

// File: tb/sim_wide_cnt_snap.sv
module sim_wide_cnt_snap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc = 1'b0, rv = 1'b0;
  logic [1:0] ra = '0;
  logic [31:0] d0; logic v0, a0, m0;
  logic [3:0]  d1; logic v1, a1, m1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wide_cnt_snap u0 (.clk(clk), .rst_n(rst_n), .inc_i(inc), .rd_valid_i(rv), .rd_addr_i(ra),
    .rd_data_o(d0), .rd_data_valid_o(v0), .acc_strb_o(a0), .mod_strb_o(m0));
  wide_cnt_snap #(.CNT_W(8), .WORD_W(4), .ADDR_W(2)) u1 (.clk(clk), .rst_n(rst_n), .inc_i(inc),
    .rd_valid_i(rv), .rd_addr_i(ra), .rd_data_o(d1), .rd_data_valid_o(v1),
    .acc_strb_o(a1), .mod_strb_o(m1));

  // reference model: index 0 = 64/32 instance, index 1 = 8/4 instance
  logic [63:0] m_cnt [2], m_snap [2], m_data [2], m_max [2];
  int          m_ww [2];
  logic        m_valid;
  string       m_tag;
  initial begin
    m_max[0] = '1; m_max[1] = 64'hFF; m_ww[0] = 32; m_ww[1] = 4;
  end

  function automatic logic [63:0] word_of(logic [63:0] v, int k, int ww);
    return (v >> (k*ww)) & ((64'd1 << ww) - 64'd1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 2; j++) begin m_cnt[j] = 0; m_snap[j] = 0; m_data[j] = 0; end
      m_valid = 0; m_tag = "R1";
    end else begin
      m_valid = rv;
      if (!rv) m_tag = "R10";
      else if (ra == 0) m_tag = "R4";
      else if (ra == 1) m_tag = "R5";
      else m_tag = "R8";
      for (int j = 0; j < 2; j++) begin
        if (!rv) m_data[j] = 0;
        else if (ra == 0) m_data[j] = word_of(m_cnt[j], 0, m_ww[j]);
        else if (ra == 1) m_data[j] = word_of(m_snap[j], 1, m_ww[j]);
        else m_data[j] = 0;
        if (rv && ra == 0) begin
          m_snap[j] = m_cnt[j];
          m_cnt[j] = inc ? 64'd1 : 64'd0;
        end else if (inc && m_cnt[j] != m_max[j]) begin
          m_cnt[j] = m_cnt[j] + 64'd1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled 2 ns after the driving edge
  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      chk(m_tag, {63'd0, v0}, {63'd0, m_valid});
      chk(m_tag, {63'd0, v1}, {63'd0, m_valid});
      chk(m_tag, {32'd0, d0}, m_data[0]);
      chk(m_tag, {60'd0, d1}, m_data[1]);
      chk("R7", {63'd0, a0}, {63'd0, rv && ra == 0});
      chk("R7", {63'd0, m0}, {63'd0, rv && ra == 0});
      chk("R7", {63'd0, a1}, {63'd0, rv && ra == 0});
    end
  end

  task automatic cyc(logic i, logic v, logic [1:0] a);
    @(negedge clk); inc = i; rv = v; ra = a;
  endtask

  // issue a read, return the data of both instances one cycle later
  task automatic rd(logic i, logic [1:0] a, output logic [31:0] r0, output logic [3:0] r1);
    cyc(i, 1'b1, a);
    @(negedge clk); inc = 0; rv = 0; ra = 0;
    #2; r0 = d0; r1 = d1;
  endtask

  task automatic run_inc(int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 2'd0);
    cyc(1'b0, 1'b0, 2'd0);
  endtask

  logic [31:0] r0; logic [3:0] r1;

  initial begin
    #3;
    chk("R1", {63'd0, v0}, 64'd0);
    chk("R1", {32'd0, d0}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, 2'd0, r0, r1); chk("R1", {32'd0, r0}, 64'd0);
    rd(1'b0, 2'd1, r0, r1); chk("R1", {32'd0, r0}, 64'd0);

    run_inc(5);
    rd(1'b0, 2'd0, r0, r1); chk("R2", {32'd0, r0}, 64'd5); chk("R4", {60'd0, r1}, 64'd5);
    rd(1'b0, 2'd1, r0, r1); chk("R5", {32'd0, r0}, 64'd0);

    run_inc(3);
    rd(1'b1, 2'd0, r0, r1); chk("R6", {32'd0, r0}, 64'd3);
    rd(1'b0, 2'd0, r0, r1); chk("R6", {32'd0, r0}, 64'd1);
    rd(1'b0, 2'd0, r0, r1); chk("R6", {32'd0, r0}, 64'd0);

    run_inc(4);
    rd(1'b0, 2'd2, r0, r1); chk("R8", {32'd0, r0}, 64'd0);
    rd(1'b0, 2'd3, r0, r1); chk("R8", {32'd0, r0}, 64'd0);
    rd(1'b0, 2'd0, r0, r1); chk("R8", {32'd0, r0}, 64'd4);

    // u1: 8-bit counter, 0x5A -> low 0xA, high 0x5 from snapshot
    run_inc(90);
    rd(1'b0, 2'd0, r0, r1); chk("R4", {60'd0, r1}, 64'hA);
    run_inc(7);
    rd(1'b0, 2'd1, r0, r1); chk("R5", {60'd0, r1}, 64'h5);
    rd(1'b0, 2'd1, r0, r1); chk("R9", {60'd0, r1}, 64'h5);

    run_inc(300);
    rd(1'b0, 2'd0, r0, r1); chk("R3", {60'd0, r1}, 64'hF); chk("R2", {32'd0, r0}, 64'd307);
    rd(1'b0, 2'd1, r0, r1); chk("R3", {60'd0, r1}, 64'hF); chk("R5", {32'd0, r0}, 64'd0);

    for (int k = 0; k < 40; k++) cyc(k % 3 != 0, k % 2 == 0, 2'(k % 4));
    cyc(1'b0, 1'b0, 2'd0);
    repeat (2) @(negedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule